// File: doc/BRIEF.md
# 14-bit Instruction Data Execute Unit

This block is the data half of a small accumulator-style processor core with a 14-bit instruction word. On each cycle where `valid_in` is high, it decodes the word and fetches one byte from an external register file. The register file is read combinationally at the 7-bit address taken from the word. The block then computes the result and, on the next clock edge, commits it. The result goes either into the internal working register W or out through a registered write port back to the register file. The carry, digit-carry and zero flags are updated under a per-instruction mask.

The instruction groups that act on data all execute here:
- byte operations between W and a register;
- single-bit clear, set and test on a register;
- operations between W and an 8-bit literal.

The test-and-skip forms raise a registered skip request. Fetch logic uses it to squash the next word.

The control-flow and power words (call, jump, both returns, return-with-literal, standby and watchdog clear) are not executed. They are reported as a registered kind code with the 11-bit target field beside it. Return-with-literal also loads W.

Top module: `alu14_exec`

## Requirements
- R1: While `rst` is high at a clock edge, W, C, DC, Z, `f_we`, `skip_req`, `ctl_kind` and `ctl_addr` all become zero.
- R2: `f_addr` always equals instruction bits 6:0. For byte operations, bit 7 (d) selects the destination: 0 loads W, 1 pulses `f_we` with `f_waddr`/`f_wdata` set and W unchanged. Results appear one edge after the word is presented.
- R3: Add and subtract, in both the register form (opcode bits 11:8 = 0111 add, 0010 subtract) and the literal form (bits 13:8 = 11111x add, 11110x literal minus W), set C on carry-out or on no-borrow. They set DC the same way for bit 3 and set Z for a zero result. Subtraction computes operand minus W.
- R4: AND (0101), inclusive OR (0100), exclusive OR (0110), complement (1001), decrement (0011), increment (1010), move-from-register (1000) and clear (0001, d selects register or W) change Z only. C and DC hold.
- R5: Rotate left (1101) and rotate right (1100) shift through C: the old C enters the vacated end and the bit pushed out becomes the new C. DC and Z hold.
- R6: Nibble swap (1110), move-W-to-register (0000 with d=1), no-operation, the skip forms and all bit operations leave C, DC and Z unchanged.
- R7: Bit operations are encoded as 01 oo bbb fffffff. oo=00 clears bit b and oo=01 sets bit b of the register, written back with all other bits kept.
- R8: `skip_req` goes high for decrement-skip (1011) or increment-skip (1111) when the result is zero, for oo=10 when the tested bit is 0, and for oo=11 when it is 1. It stays low otherwise.
- R9: Literal words take the operand from bits 7:0 and write W: AND 111001, OR 111000, XOR 111010, move 1100xx. Code 111011 and the 00 0000 0xxx xxxx words not listed in R10 do nothing.
- R10: `ctl_kind` reports 1 for call (100xxx), 2 for jump (101xxx), 3 for return (0x0008), 4 for interrupt return (0x0009), 5 for return-with-literal (1101xx, which also loads W with the literal), 6 for standby (0x0063) and 7 for watchdog clear (0x0064). Call and jump also drive bits 10:0 of the word on `ctl_addr`. These words never write the register file or touch the flags.
- R11: A cycle with `valid_in` low leaves W and the flags unchanged and gives `f_we`=0, `skip_req`=0 and `ctl_kind`=0 on the next cycle, whatever `instr` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Instruction word is valid this cycle |
| instr | input | 14 | Instruction word |
| f_addr | output | 7 | Register-file read address |
| f_rdata | input | 8 | Register-file read data for `f_addr` |
| w_q | output | 8 | Working register W |
| c_q | output | 1 | Carry / no-borrow flag |
| dc_q | output | 1 | Digit carry flag |
| z_q | output | 1 | Zero flag |
| f_we | output | 1 | Register-file write strobe |
| f_waddr | output | 7 | Register-file write address |
| f_wdata | output | 8 | Register-file write data |
| skip_req | output | 1 | Skip the next instruction |
| ctl_kind | output | 3 | Control word kind (R10 codes) |
| ctl_addr | output | 11 | Target field of call/jump |

## Verification
The decrement-skip and increment-skip words with d=1 do two things in the same cycle. They write the new value back to the register file and they decide the skip from that same value. The bench provokes this directly by loading registers with 0x01 and 0xFF before those words. Randomly drawn d bits provoke it again. It judges `f_we`, `f_wdata` and `skip_req` together against one reference result. Rotates are also fed the carry left by the previous random instruction, so the carry flag is checked as both input and output.

// File: rtl/alu14_pkg.sv
package alu14_pkg;
  localparam int INSN_W   = 14;
  localparam int DATA_W   = 8;
  localparam int FADDR_W  = 7;
  localparam int BSEL_W   = $clog2(DATA_W);
  localparam int NIB_W    = DATA_W / 2;
  localparam int TARGET_W = 11;

  typedef enum logic [4:0] {
    ALU_NOP, ALU_ADD, ALU_SUB, ALU_AND, ALU_IOR, ALU_XOR, ALU_COM,
    ALU_DEC, ALU_INC, ALU_PASS_OPND, ALU_PASS_W, ALU_ZERO, ALU_RL,
    ALU_RR, ALU_SWAP, ALU_BCLR, ALU_BSET, ALU_BTST
  } alu_op_e;

  typedef enum logic [2:0] {
    CTL_NONE = 3'd0, CTL_CALL = 3'd1, CTL_GOTO = 3'd2, CTL_RETURN = 3'd3,
    CTL_RETFIE = 3'd4, CTL_RETLW = 3'd5, CTL_SLEEP = 3'd6, CTL_CLRWDT = 3'd7
  } ctl_e;

  typedef enum logic [1:0] {
    SKIP_NEVER, SKIP_ZERO, SKIP_BIT_LO, SKIP_BIT_HI
  } skip_e;

  typedef struct packed {
    alu_op_e           op;
    logic              use_lit;
    logic              wr_w;
    logic              wr_f;
    logic              upd_c;
    logic              upd_dc;
    logic              upd_z;
    skip_e             skip;
    logic [BSEL_W-1:0] bitsel;
    ctl_e              ctl;
  } dec_t;
endpackage

// File: rtl/alu14_decode.sv
module alu14_decode
  import alu14_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  always_comb begin
    dec        = '0;
    dec.op     = ALU_NOP;
    dec.skip   = SKIP_NEVER;
    dec.ctl    = CTL_NONE;
    dec.bitsel = insn[FADDR_W +: BSEL_W];
    unique case (insn[13:12])
      2'b00: begin
        dec.wr_w = ~insn[7];
        dec.wr_f = insn[7];
        case (insn[11:8])
          4'h7: begin dec.op = ALU_ADD; dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
          4'h2: begin dec.op = ALU_SUB; dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
          4'h5: begin dec.op = ALU_AND;       dec.upd_z = 1'b1; end
          4'h4: begin dec.op = ALU_IOR;       dec.upd_z = 1'b1; end
          4'h6: begin dec.op = ALU_XOR;       dec.upd_z = 1'b1; end
          4'h9: begin dec.op = ALU_COM;       dec.upd_z = 1'b1; end
          4'h3: begin dec.op = ALU_DEC;       dec.upd_z = 1'b1; end
          4'hA: begin dec.op = ALU_INC;       dec.upd_z = 1'b1; end
          4'h8: begin dec.op = ALU_PASS_OPND; dec.upd_z = 1'b1; end
          4'h1: begin dec.op = ALU_ZERO;      dec.upd_z = 1'b1; end
          4'hD: begin dec.op = ALU_RL;        dec.upd_c = 1'b1; end
          4'hC: begin dec.op = ALU_RR;        dec.upd_c = 1'b1; end
          4'hE: dec.op = ALU_SWAP;
          4'hB: begin dec.op = ALU_DEC; dec.skip = SKIP_ZERO; end
          4'hF: begin dec.op = ALU_INC; dec.skip = SKIP_ZERO; end
          default: begin
            // 0000: store W when d=1, otherwise system words or no-op
            if (insn[7]) begin
              dec.op = ALU_PASS_W;
            end else begin
              dec.wr_w = 1'b0;
              case (insn[6:0])
                7'h08:   dec.ctl = CTL_RETURN;
                7'h09:   dec.ctl = CTL_RETFIE;
                7'h63:   dec.ctl = CTL_SLEEP;
                7'h64:   dec.ctl = CTL_CLRWDT;
                default: dec.ctl = CTL_NONE;
              endcase
            end
          end
        endcase
      end
      2'b01: begin
        case (insn[11:10])
          2'b00: begin dec.op = ALU_BCLR; dec.wr_f = 1'b1; end
          2'b01: begin dec.op = ALU_BSET; dec.wr_f = 1'b1; end
          2'b10: begin dec.op = ALU_BTST; dec.skip = SKIP_BIT_LO; end
          default: begin dec.op = ALU_BTST; dec.skip = SKIP_BIT_HI; end
        endcase
      end
      2'b10: dec.ctl = insn[11] ? CTL_GOTO : CTL_CALL;
      default: begin
        dec.use_lit = 1'b1;
        casez (insn[11:8])
          4'b111?: begin dec.op = ALU_ADD; dec.wr_w = 1'b1; dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
          4'b110?: begin dec.op = ALU_SUB; dec.wr_w = 1'b1; dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
          4'b1001: begin dec.op = ALU_AND; dec.wr_w = 1'b1; dec.upd_z = 1'b1; end
          4'b1000: begin dec.op = ALU_IOR; dec.wr_w = 1'b1; dec.upd_z = 1'b1; end
          4'b1010: begin dec.op = ALU_XOR; dec.wr_w = 1'b1; dec.upd_z = 1'b1; end
          4'b00??: begin dec.op = ALU_PASS_OPND; dec.wr_w = 1'b1; end
          4'b01??: begin dec.op = ALU_PASS_OPND; dec.wr_w = 1'b1; dec.ctl = CTL_RETLW; end
          default: dec.op = ALU_NOP;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/alu14_datapath.sv
module alu14_datapath
  import alu14_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] w,
  input  logic              c_in,
  input  logic [BSEL_W-1:0] bitsel,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              dc_out,
  output logic              z_out,
  output logic              bit_val
);
  logic [DATA_W:0]       sum;
  logic [NIB_W:0]        nib;
  logic [DATA_W-1:0]     addend;
  logic [DATA_W-1:0]     bmask;
  logic                  cin_arith;

  // subtraction is operand + ~W + 1; carry out is then "no borrow"
  assign cin_arith = (op == ALU_SUB);
  assign addend    = cin_arith ? ~w : w;
  assign sum       = {1'b0, opnd} + {1'b0, addend} + {{DATA_W{1'b0}}, cin_arith};
  assign nib       = {1'b0, opnd[NIB_W-1:0]} + {1'b0, addend[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, cin_arith};
  assign bmask     = {{(DATA_W-1){1'b0}}, 1'b1} << bitsel;
  assign bit_val   = opnd[bitsel];

  always_comb begin
    res    = opnd;
    c_out  = c_in;
    dc_out = nib[NIB_W];
    unique case (op)
      ALU_ADD, ALU_SUB: begin res = sum[DATA_W-1:0]; c_out = sum[DATA_W]; end
      ALU_AND:       res = opnd & w;
      ALU_IOR:       res = opnd | w;
      ALU_XOR:       res = opnd ^ w;
      ALU_COM:       res = ~opnd;
      ALU_DEC:       res = opnd - 1'b1;
      ALU_INC:       res = opnd + 1'b1;
      ALU_PASS_W:    res = w;
      ALU_ZERO:      res = '0;
      ALU_RL: begin res = {opnd[DATA_W-2:0], c_in}; c_out = opnd[DATA_W-1]; end
      ALU_RR: begin res = {c_in, opnd[DATA_W-1:1]}; c_out = opnd[0]; end
      ALU_SWAP:      res = {opnd[NIB_W-1:0], opnd[DATA_W-1:NIB_W]};
      ALU_BCLR:      res = opnd & ~bmask;
      ALU_BSET:      res = opnd | bmask;
      default:       res = opnd;
    endcase
  end

  assign z_out = (res == '0);
endmodule

// File: rtl/alu14_exec.sv
module alu14_exec
  import alu14_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_in,
  input  logic [13:0]         instr,
  output logic [6:0]          f_addr,
  input  logic [7:0]          f_rdata,
  output logic [7:0]          w_q,
  output logic                c_q,
  output logic                dc_q,
  output logic                z_q,
  output logic                f_we,
  output logic [6:0]          f_waddr,
  output logic [7:0]          f_wdata,
  output logic                skip_req,
  output logic [2:0]          ctl_kind,
  output logic [10:0]         ctl_addr
);
  dec_t              dec;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] res;
  logic              c_n, dc_n, z_n, bit_val, skip_n;

  assign f_addr = instr[FADDR_W-1:0];
  assign opnd   = dec.use_lit ? instr[DATA_W-1:0] : f_rdata;

  alu14_decode u_dec (
    .insn (instr),
    .dec  (dec)
  );

  alu14_datapath u_dp (
    .op      (dec.op),
    .opnd    (opnd),
    .w       (w_q),
    .c_in    (c_q),
    .bitsel  (dec.bitsel),
    .res     (res),
    .c_out   (c_n),
    .dc_out  (dc_n),
    .z_out   (z_n),
    .bit_val (bit_val)
  );

  always_comb begin
    unique case (dec.skip)
      SKIP_ZERO:   skip_n = z_n;
      SKIP_BIT_LO: skip_n = ~bit_val;
      SKIP_BIT_HI: skip_n = bit_val;
      default:     skip_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q      <= '0;
      c_q      <= 1'b0;
      dc_q     <= 1'b0;
      z_q      <= 1'b0;
      f_we     <= 1'b0;
      f_waddr  <= '0;
      f_wdata  <= '0;
      skip_req <= 1'b0;
      ctl_kind <= CTL_NONE;
      ctl_addr <= '0;
    end else begin
      f_we     <= valid_in & dec.wr_f;
      skip_req <= valid_in & skip_n;
      ctl_kind <= valid_in ? dec.ctl : CTL_NONE;
      if (valid_in) begin
        f_waddr  <= instr[FADDR_W-1:0];
        f_wdata  <= res;
        ctl_addr <= instr[TARGET_W-1:0];
        if (dec.wr_w)   w_q  <= res;
        if (dec.upd_c)  c_q  <= c_n;
        if (dec.upd_dc) dc_q <= dc_n;
        if (dec.upd_z)  z_q  <= z_n;
      end
    end
  end
endmodule

// File: rtl/alu14_exec_chk.sv
module alu14_exec_chk (
  input logic       clk,
  input logic       rst,
  input logic       valid_in,
  input logic [7:0] w_q,
  input logic       c_q,
  input logic       dc_q,
  input logic       z_q,
  input logic       f_we,
  input logic       skip_req,
  input logic [2:0] ctl_kind
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(valid_in) |-> (!f_we && !skip_req && ctl_kind == 3'd0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(valid_in) |-> $stable({w_q, c_q, dc_q, z_q}));

  p_fwrite_keeps_w_r2: assert property (@(posedge clk) disable iff (rst)
    f_we |-> $stable(w_q));

  p_ctl_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl_kind != 3'd0) |-> (!f_we && !skip_req));

  p_ctl_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl_kind != 3'd0) |-> $stable({c_q, dc_q, z_q}));

  p_skip_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
    skip_req |-> $stable({c_q, dc_q, z_q}));
endmodule

bind alu14_exec alu14_exec_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid_in (valid_in),
  .w_q      (w_q),
  .c_q      (c_q),
  .dc_q     (dc_q),
  .z_q      (z_q),
  .f_we     (f_we),
  .skip_req (skip_req),
  .ctl_kind (ctl_kind)
);

// File: tb/test_alu14_exec.sv
`timescale 1ns/1ps
module test_alu14_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [13:0] instr = '0;
  logic [6:0]  f_addr;
  logic [7:0]  f_rdata;
  logic [7:0]  w_q;
  logic        c_q, dc_q, z_q, f_we, skip_req;
  logic [6:0]  f_waddr;
  logic [7:0]  f_wdata;
  logic [2:0]  ctl_kind;
  logic [10:0] ctl_addr;

  logic [7:0] regs [0:127];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state
  logic [7:0] mw;
  logic       mc, mdc, mz;

  always #2 clk = ~clk;

  assign f_rdata = regs[f_addr];
  always @(posedge clk) if (f_we) regs[f_waddr] <= f_wdata;

  alu14_exec i_alu14_exec (
    .clk(clk), .rst(rst), .valid_in(valid_in), .instr(instr),
    .f_addr(f_addr), .f_rdata(f_rdata), .w_q(w_q), .c_q(c_q), .dc_q(dc_q),
    .z_q(z_q), .f_we(f_we), .f_waddr(f_waddr), .f_wdata(f_wdata),
    .skip_req(skip_req), .ctl_kind(ctl_kind), .ctl_addr(ctl_addr)
  );

  function automatic string req_of(input logic [13:0] ins);
    case (ins[13:12])
      2'b01: return (ins[11]) ? "R8" : "R7";
      2'b10: return "R10";
      2'b11: return (ins[11:10] == 2'b01) ? "R10" : (ins[11:9] == 3'b111 || ins[11:9] == 3'b110) ? "R3" : "R9";
      default: begin
        case (ins[11:8])
          4'h7, 4'h2: return "R3";
          4'hD, 4'hC: return "R5";
          4'hB, 4'hF: return "R8";
          4'hE:       return "R6";
          4'h0:       return ins[7] ? "R6" : "R10";
          default:    return "R4";
        endcase
      end
    endcase
  endfunction

  // expected outputs: {w, c, dc, z, we, wdata, skip, kind, addr}
  task automatic expect_of(input logic [13:0] ins, input logic [7:0] fv,
                           output logic [7:0] ew, output logic ec, output logic edc,
                           output logic ez, output logic ewe, output logic [7:0] ewd,
                           output logic esk, output logic [2:0] ek);
    logic [7:0] k, res;
    logic [2:0] b;
    logic d, hasres, dz;
    int a;
    k = ins[7:0]; b = ins[9:7]; d = ins[7];
    ew = mw; ec = mc; edc = mdc; ez = mz; ewe = 0; ewd = 0; esk = 0; ek = 0;
    res = 0; hasres = 0; dz = 0;
    case (ins[13:12])
      2'b00: begin
        hasres = 1;
        case (ins[11:8])
          4'h7: begin a = fv + mw; res = a[7:0]; ec = a > 255; edc = (fv[3:0] + mw[3:0]) > 15; dz = 1; end
          4'h2: begin res = fv - mw; ec = fv >= mw; edc = fv[3:0] >= mw[3:0]; dz = 1; end
          4'h5: begin res = fv & mw; dz = 1; end
          4'h4: begin res = fv | mw; dz = 1; end
          4'h6: begin res = fv ^ mw; dz = 1; end
          4'h9: begin res = ~fv; dz = 1; end
          4'h3: begin res = fv - 8'd1; dz = 1; end
          4'hA: begin res = fv + 8'd1; dz = 1; end
          4'h8: begin res = fv; dz = 1; end
          4'h1: begin res = 8'd0; dz = 1; end
          4'hD: begin res = {fv[6:0], mc}; ec = fv[7]; end
          4'hC: begin res = {mc, fv[7:1]}; ec = fv[0]; end
          4'hE: res = {fv[3:0], fv[7:4]};
          4'hB: begin res = fv - 8'd1; esk = (res == 0); end
          4'hF: begin res = fv + 8'd1; esk = (res == 0); end
          default: begin
            if (d) res = mw;
            else begin
              hasres = 0;
              case (ins[6:0])
                7'h08: ek = 3; 7'h09: ek = 4; 7'h63: ek = 6; 7'h64: ek = 7;
                default: ek = 0;
              endcase
            end
          end
        endcase
        if (dz) ez = (res == 0);
        if (hasres) begin
          if (d) begin ewe = 1; ewd = res; end
          else ew = res;
        end
      end
      2'b01: begin
        case (ins[11:10])
          2'b00: begin ewe = 1; ewd = fv; ewd[b] = 1'b0; end
          2'b01: begin ewe = 1; ewd = fv; ewd[b] = 1'b1; end
          2'b10: esk = (fv[b] == 1'b0);
          default: esk = (fv[b] == 1'b1);
        endcase
      end
      2'b10: ek = ins[11] ? 3'd2 : 3'd1;
      default: begin
        casez (ins[11:8])
          4'b111?: begin a = k + mw; ew = a[7:0]; ec = a > 255; edc = (k[3:0] + mw[3:0]) > 15; ez = (ew == 0); end
          4'b110?: begin ew = k - mw; ec = k >= mw; edc = k[3:0] >= mw[3:0]; ez = (ew == 0); end
          4'b1001: begin ew = k & mw; ez = (ew == 0); end
          4'b1000: begin ew = k | mw; ez = (ew == 0); end
          4'b1010: begin ew = k ^ mw; ez = (ew == 0); end
          4'b00??: ew = k;
          4'b01??: begin ew = k; ek = 5; end
          default: ;
        endcase
      end
    endcase
  endtask

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic run(input logic [13:0] ins);
    logic [7:0] fv, ew, ewd;
    logic ec, edc, ez, ewe, esk;
    logic [2:0] ek;
    logic [10:0] ea;
    @(negedge clk);
    instr = ins; valid_in = 1'b1;
    fv = regs[ins[6:0]];
    expect_of(ins, fv, ew, ec, edc, ez, ewe, ewd, esk, ek);
    ea = (ek == 3'd1 || ek == 3'd2) ? ins[10:0] : 11'd0;
    #0.5;
    check("R2", {41'd0, f_addr}, {41'd0, ins[6:0]});
    @(negedge clk);
    valid_in = 1'b0;
    instr = 14'($urandom);
    check(req_of(ins),
          {6'd0, w_q, c_q, dc_q, z_q, f_we, (f_we ? f_wdata : 8'd0), (f_we ? f_waddr : 7'd0),
           skip_req, ctl_kind, ((ctl_kind == 3'd1 || ctl_kind == 3'd2) ? ctl_addr : 11'd0)},
          {6'd0, ew, ec, edc, ez, ewe, ewd, (ewe ? ins[6:0] : 7'd0), esk, ek, ea});
    mw = ew; mc = ec; mdc = edc; mz = ez;
    @(negedge clk);
    // idle cycle with garbage on instr: nothing may happen (R11)
    check("R11", {33'd0, f_we, skip_req, ctl_kind, w_q, c_q, dc_q, z_q},
                 {33'd0, 1'b0, 1'b0, 3'd0, mw, mc, mdc, mz});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) regs[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", {18'd0, w_q, c_q, dc_q, z_q, f_we, skip_req, ctl_kind, ctl_addr},
                {48'd0});
    rst = 1'b0;
    mw = 0; mc = 0; mdc = 0; mz = 0;
    // R3 add overflow and nibble carry
    run(14'h30FF);            // move literal 0xFF
    run(14'h3E01);            // add literal 1 -> 0, C DC Z set
    run(14'h3C00);            // literal 0 minus W(0) -> C=1 Z=1
    run(14'h3005); run(14'h3C03); // 3 - 5: borrow
    run(14'h3008); run(14'h3C19); // 0x19-0x08: nibble no borrow
    // R5 rotate with both carry values; R2 both destinations
    run(14'h3081); run(14'h00A0);      // store 0x81 at 0x20
    run(14'h0DA0); run(14'h0D20); run(14'h0CA0); run(14'h0C20);
    // R8 decrement/increment skip hitting zero, written back
    run(14'h3001); run(14'h00A1); run(14'h0BA1); run(14'h0BA1);
    run(14'h30FF); run(14'h00A2); run(14'h0FA2); run(14'h0F22);
    // R7/R8 bit ops on bits 0 and 7
    run(14'h1022); run(14'h17A2); run(14'h1822); run(14'h1C22);
    run(14'h1BA2); run(14'h1FA2); run(14'h13A2); run(14'h1BA2);
    // R4 clears, R6 swap and no-ops
    run(14'h01A3); run(14'h0103); run(14'h0EA2); run(14'h0000); run(14'h0060);
    run(14'h3B55); run(14'h0005);
    // R10 control words
    run(14'h2123); run(14'h2FFF); run(14'h0008); run(14'h0009);
    run(14'h0063); run(14'h0064); run(14'h3477);
    // random mix
    for (int i = 0; i < 3000; i++) run(14'($urandom));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule